// File: doc/BRIEF.md
# Display Event Interrupt Controller

This block gathers single-cycle event pulses from a display pipeline (frame finished, scan-out finished, lost synchronisation, AC-bias counter reached, FIFO underflow, palette load done, and end of frame for each of two frame buffers) and turns them into one interrupt line for the processor. Each event sets a sticky bit in a raw status register whether or not it is enabled. A masked view shows only the enabled events. The enable mask is changed through two write ports: one port only sets bits and the other only clears them. Because of this, two software agents can change the mask without a read-modify-write.

Software acknowledges an event by writing back the value it read from the masked view. An event that arrives in the same cycle as its acknowledge is kept. The interrupt line gives a single one-cycle pulse and then stays quiet. It can pulse again only after software writes the end-of-service register. At that point the line is re-evaluated, and it pulses if an enabled event is still pending.

Register word addresses on `wr_addr_i` and `rd_addr_i`: 0 raw status, 1 masked status, 2 enable-set, 3 enable-clear, 4 end-of-service. Reads of addresses 2 and 3 both return the enable mask. Address 4 and unused addresses read as zero.

Top module: `irq_event_ctrl`

## Requirements
- R1: After reset, raw status, masked status and the enable mask read 0, `irq_o` is low, and the line is armed, so the first enabled pending event can raise it without an end-of-service write.
- R2: Event bits sit at fixed positions: frame done 0, scan-out done 1, sync lost 2, AC-bias count 3, FIFO underflow 5, palette loaded 6, buffer-0 end 8, buffer-1 end 9. A pulse on an implemented `ev_i` bit sets that raw bit, and a read in the next cycle shows it, whatever the enable. Bits 4, 7 and 10 and above always read 0 in raw status and in the enable mask, and inputs or writes at those positions have no effect.
- R3: Masked status (address 1) always reads as raw status AND the enable mask.
- R4: Writing to address 2 sets each enable bit written as 1. Bits written as 0 keep their value. The new mask can be read from the next cycle at address 2 or 3.
- R5: Writing to address 3 clears each enable bit written as 1. Bits written as 0 keep their value.
- R6: Writing to address 1 clears each raw bit that is written as 1 and is enabled. Raw bits written as 0, and pending bits that are not enabled, stay set.
- R7: If an event pulse and an acknowledge of the same bit fall in the same cycle, the bit stays set.
- R8: While armed, `irq_o` goes high for exactly one cycle, in the cycle after the first cycle in which any enabled bit is pending. The line is then disarmed and stays low even though bits remain pending.
- R9: A write to address 4 re-arms the line. If an enabled bit is pending, `irq_o` pulses in the second cycle after the write cycle. Otherwise it stays low until an enabled bit becomes pending, and then it pulses one cycle later.
- R10: Writes to address 0 (raw status) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ev_i | input | EV_W (10) | Event pulses, one bit per event position |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W (3) | Register word address for writes |
| wr_data_i | input | DATA_W (32) | Write data |
| rd_addr_i | input | ADDR_W (3) | Register word address for reads |
| rd_data_o | output | DATA_W (32) | Read data, combinational from `rd_addr_i` |
| irq_o | output | 1 | Interrupt line, one-cycle pulse |

## Verification
Writes and event pulses are captured on the clock edge that ends the cycle in which they are driven, and reads are combinational. The bench therefore reads register values at the first falling edge after that capture edge. `irq_o` is registered once after the state it depends on, so a pulse caused by an event, an enable write or an end-of-service write shows up one full cycle after the capture edge. Each scenario task samples `irq_o` at successive falling edges and expects low, then high, then low again. This pins the pulse to a single cycle and catches any repeat before re-arming.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    // Register word addresses
    typedef enum logic [2:0] {
        REG_RAW    = 3'd0,
        REG_PEND   = 3'd1,
        REG_EN_SET = 3'd2,
        REG_EN_CLR = 3'd3,
        REG_EOI    = 3'd4
    } irqc_reg_e;

    // Event bit positions
    localparam int EV_FRAME_DONE = 0;
    localparam int EV_SCAN_DONE  = 1;
    localparam int EV_SYNC_LOST  = 2;
    localparam int EV_BIAS_COUNT = 3;
    localparam int EV_UNDERFLOW  = 5;
    localparam int EV_PAL_LOADED = 6;
    localparam int EV_BUF0_END   = 8;
    localparam int EV_BUF1_END   = 9;

    localparam int EV_W_DEFAULT = 10;

    localparam logic [EV_W_DEFAULT-1:0] EV_MASK_DEFAULT =
        EV_W_DEFAULT'((1 << EV_FRAME_DONE) | (1 << EV_SCAN_DONE) |
                      (1 << EV_SYNC_LOST)  | (1 << EV_BIAS_COUNT) |
                      (1 << EV_UNDERFLOW)  | (1 << EV_PAL_LOADED) |
                      (1 << EV_BUF0_END)   | (1 << EV_BUF1_END));

    // Decoded write strobes
    typedef struct packed {
        logic en_set;
        logic en_clr;
        logic ack;
        logic eoi;
    } irqc_stb_t;

endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
    import irqc_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    output irqc_stb_t         stb_o
);

    irqc_stb_t stb_d;

    always_comb begin
        stb_d = '0;
        if (wr_en_i) begin
            unique case (wr_addr_i)
                ADDR_W'(REG_EN_SET): stb_d.en_set = 1'b1;
                ADDR_W'(REG_EN_CLR): stb_d.en_clr = 1'b1;
                ADDR_W'(REG_PEND):   stb_d.ack    = 1'b1;
                ADDR_W'(REG_EOI):    stb_d.eoi    = 1'b1;
                default:             stb_d = '0;   // raw status and unused: ignored
            endcase
        end
    end

    assign stb_o = stb_d;

endmodule

// File: rtl/irqc_state.sv
module irqc_state
    import irqc_pkg::*;
#(
    parameter int              EV_W    = EV_W_DEFAULT,
    parameter logic [EV_W-1:0] EV_MASK = EV_MASK_DEFAULT
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [EV_W-1:0] ev_i,
    input  irqc_stb_t       stb_i,
    input  logic [EV_W-1:0] wdata_i,
    output logic [EV_W-1:0] raw_o,
    output logic [EV_W-1:0] en_o
);

    typedef struct packed {
        logic [EV_W-1:0] raw;
        logic [EV_W-1:0] en;
    } state_t;

    state_t st_d, st_q;
    logic [EV_W-1:0] clr_bits_d;

    always_comb begin
        st_d       = st_q;
        clr_bits_d = '0;
        if (stb_i.en_set) begin
            st_d.en = st_q.en | (wdata_i & EV_MASK);
        end
        if (stb_i.en_clr) begin
            st_d.en = st_q.en & ~wdata_i;
        end
        if (stb_i.ack) begin
            clr_bits_d = wdata_i & st_q.en;
        end
        // a new event outranks an acknowledge of the same bit
        st_d.raw = (st_q.raw & ~clr_bits_d) | (ev_i & EV_MASK);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign raw_o = st_q.raw;
    assign en_o  = st_q.en;

endmodule

// File: rtl/irqc_line.sv
module irqc_line (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pending_i,
    input  logic eoi_i,
    output logic armed_o,
    output logic irq_o
);

    typedef struct packed {
        logic armed;
        logic irq;
    } line_t;

    line_t ln_d, ln_q;
    logic  fire_d;

    always_comb begin
        ln_d   = ln_q;
        fire_d = ln_q.armed & pending_i;
        ln_d.irq = fire_d;
        if (eoi_i) begin
            ln_d.armed = 1'b1;
        end else if (fire_d) begin
            ln_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ln_q <= '{armed: 1'b1, irq: 1'b0};
        end else begin
            ln_q <= ln_d;
        end
    end

    assign armed_o = ln_q.armed;
    assign irq_o   = ln_q.irq;

endmodule

// File: rtl/irq_event_ctrl.sv
module irq_event_ctrl
    import irqc_pkg::*;
#(
    parameter int              ADDR_W  = 3,
    parameter int              DATA_W  = 32,
    parameter int              EV_W    = EV_W_DEFAULT,
    parameter logic [EV_W-1:0] EV_MASK = EV_MASK_DEFAULT
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [EV_W-1:0]   ev_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              irq_o
);

    irqc_stb_t       stb;
    logic            set_stb, clr_stb, ack_stb, eoi_stb;
    logic [EV_W-1:0] wdata;
    logic [EV_W-1:0] raw_q, en_q, pend;
    logic            armed_q;
    logic            unused_wr_hi;

    assign wdata        = wr_data_i[EV_W-1:0];
    assign unused_wr_hi = ^wr_data_i[DATA_W-1:EV_W];

    irqc_decode #(.ADDR_W(ADDR_W)) u_decode (
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .stb_o     (stb)
    );

    assign set_stb = stb.en_set;
    assign clr_stb = stb.en_clr;
    assign ack_stb = stb.ack;
    assign eoi_stb = stb.eoi;

    irqc_state #(.EV_W(EV_W), .EV_MASK(EV_MASK)) u_state (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .ev_i    (ev_i),
        .stb_i   (stb),
        .wdata_i (wdata),
        .raw_o   (raw_q),
        .en_o    (en_q)
    );

    assign pend = raw_q & en_q;

    irqc_line u_line (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .pending_i (|pend),
        .eoi_i     (eoi_stb),
        .armed_o   (armed_q),
        .irq_o     (irq_o)
    );

    always_comb begin
        rd_data_o = '0;
        unique case (rd_addr_i)
            ADDR_W'(REG_RAW):    rd_data_o = DATA_W'(raw_q);
            ADDR_W'(REG_PEND):   rd_data_o = DATA_W'(pend);
            ADDR_W'(REG_EN_SET): rd_data_o = DATA_W'(en_q);
            ADDR_W'(REG_EN_CLR): rd_data_o = DATA_W'(en_q);
            default:             rd_data_o = '0;
        endcase
    end

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
    parameter int              EV_W    = 10,
    parameter logic [EV_W-1:0] EV_MASK = '1
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic [EV_W-1:0] ev_i,
    input logic [EV_W-1:0] wdata,
    input logic            set_stb,
    input logic            clr_stb,
    input logic            ack_stb,
    input logic            eoi_stb,
    input logic [EV_W-1:0] raw_q,
    input logic [EV_W-1:0] en_q,
    input logic            armed_q,
    input logic            irq_o
);

    assert_raw_capture_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|(ev_i & EV_MASK)) |=>
            ((raw_q & $past(ev_i & EV_MASK)) == $past(ev_i & EV_MASK)));

    assert_en_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_stb |=> ((en_q & $past(wdata & EV_MASK)) == $past(wdata & EV_MASK)));

    assert_en_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_stb |=> ((en_q & $past(wdata)) == '0));

    assert_event_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_stb && (|(ev_i & wdata & EV_MASK))) |=>
            ((raw_q & $past(ev_i & wdata & EV_MASK)) == $past(ev_i & wdata & EV_MASK)));

    assert_single_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_o && !$past(eoi_stb)) |=> !irq_o);

    assert_rearm_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (eoi_stb && (|(raw_q & en_q))) |=> ##1 irq_o);

    assert_quiet_disarmed_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !armed_q |=> !irq_o);

endmodule

bind irq_event_ctrl irqc_checker #(.EV_W(EV_W), .EV_MASK(EV_MASK)) u_irqc_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ev_i    (ev_i),
    .wdata   (wdata),
    .set_stb (set_stb),
    .clr_stb (clr_stb),
    .ack_stb (ack_stb),
    .eoi_stb (eoi_stb),
    .raw_q   (raw_q),
    .en_q    (en_q),
    .armed_q (armed_q),
    .irq_o   (irq_o)
);

// File: tb/tb_irq_event_ctrl.sv
module tb_irq_event_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 3;
    localparam int DATA_W     = 32;
    localparam int EV_W       = 10;
    localparam int WD_LIMIT   = 10000;

    localparam logic [ADDR_W-1:0] A_RAW  = 3'd0;
    localparam logic [ADDR_W-1:0] A_PEND = 3'd1;
    localparam logic [ADDR_W-1:0] A_SET  = 3'd2;
    localparam logic [ADDR_W-1:0] A_CLR  = 3'd3;
    localparam logic [ADDR_W-1:0] A_EOI  = 3'd4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [EV_W-1:0]   ev = '0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [DATA_W-1:0] rd_data;
    logic              irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_event_ctrl dut (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .ev_i      (ev),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .irq_o     (irq)
    );

    task automatic chk(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd_chk(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] exp, input string tag);
        rd_addr = a;
        #1;
        chk(tag, rd_data, exp);
    endtask

    task automatic irq_chk(input logic exp, input string tag);
        chk(tag, DATA_W'(irq), DATA_W'(exp));
    endtask

    task automatic reg_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic ev_pulse(input logic [EV_W-1:0] e);
        ev = e;
        step();
        ev = '0;
    endtask

    task automatic t_reset();
        rd_chk(A_RAW,  32'h0, "R1 raw after reset");
        rd_chk(A_PEND, 32'h0, "R1 masked after reset");
        rd_chk(A_SET,  32'h0, "R1 enable after reset");
        irq_chk(1'b0, "R1 irq after reset");
    endtask

    task automatic t_raw_only();
        ev_pulse(10'h3FF);
        rd_chk(A_RAW,  32'h36F, "R2 raw captures implemented bits only");
        rd_chk(A_PEND, 32'h0,   "R3 masked empty with no enable");
        irq_chk(1'b0, "R2 no irq while disabled");
        step();
        irq_chk(1'b0, "R2 no irq while disabled +1");
        step();
        irq_chk(1'b0, "R2 no irq while disabled +2");
    endtask

    task automatic t_enable_set();
        reg_write(A_SET, 32'h101);
        rd_chk(A_SET,  32'h101, "R4 enable via set addr");
        rd_chk(A_CLR,  32'h101, "R4 enable via clear addr");
        rd_chk(A_PEND, 32'h101, "R3 masked = raw & en");
        irq_chk(1'b0, "R8 irq not yet");
        step();
        irq_chk(1'b1, "R1 R8 first pulse while armed");
        step();
        irq_chk(1'b0, "R8 pulse one cycle");
        step();
        irq_chk(1'b0, "R8 disarmed stays low");
        reg_write(A_SET, 32'h0);
        rd_chk(A_SET, 32'h101, "R4 zeros keep enables");
        reg_write(A_SET, 32'hFFFF_FC90);
        rd_chk(A_SET, 32'h101, "R2 reserved enable bits stay 0");
    endtask

    task automatic t_enable_clear();
        reg_write(A_CLR, 32'h100);
        rd_chk(A_SET,  32'h001, "R5 clear bit 8");
        rd_chk(A_PEND, 32'h001, "R5 R3 masked after clear");
        reg_write(A_CLR, 32'h0);
        rd_chk(A_SET, 32'h001, "R5 zeros keep enables");
    endtask

    task automatic t_ack();
        reg_write(A_PEND, 32'h36F);
        rd_chk(A_RAW,  32'h36E, "R6 ack clears only enabled bits");
        rd_chk(A_PEND, 32'h0,   "R6 masked empty after ack");
        reg_write(A_RAW, 32'h3FF);
        rd_chk(A_RAW, 32'h36E, "R10 raw write of ones ignored");
        reg_write(A_RAW, 32'h0);
        rd_chk(A_RAW, 32'h36E, "R10 raw write of zeros ignored");
    endtask

    task automatic t_eoi();
        reg_write(A_EOI, 32'h0);
        irq_chk(1'b0, "R9 eoi with nothing pending");
        step();
        irq_chk(1'b0, "R9 eoi with nothing pending +1");
        step();
        irq_chk(1'b0, "R9 eoi with nothing pending +2");
        reg_write(A_SET, 32'h002);
        irq_chk(1'b0, "R9 armed, pulse not yet");
        step();
        irq_chk(1'b1, "R9 armed line pulses when pending appears");
        step();
        irq_chk(1'b0, "R8 single pulse");
        step();
        irq_chk(1'b0, "R8 still pending but disarmed");
        reg_write(A_EOI, 32'h0);
        irq_chk(1'b0, "R9 eoi pulse not yet");
        step();
        irq_chk(1'b1, "R9 eoi re-arms with pending");
        step();
        irq_chk(1'b0, "R9 pulse ends");
        step();
        irq_chk(1'b0, "R9 no second pulse");
    endtask

    task automatic t_collide();
        ev = 10'h002; wr_en = 1'b1; wr_addr = A_PEND; wr_data = 32'h002;
        step();
        ev = '0; wr_en = 1'b0; wr_data = '0;
        rd_chk(A_RAW, 32'h36E, "R7 event wins over ack");
        reg_write(A_PEND, 32'h002);
        rd_chk(A_RAW,  32'h36C, "R6 ack without event clears");
        rd_chk(A_PEND, 32'h0,   "R3 masked empty");
        reg_write(A_EOI, 32'h0);
        step();
        irq_chk(1'b0, "R9 armed, nothing pending");
        ev_pulse(10'h001);
        rd_chk(A_RAW,  32'h36D, "R2 frame done at bit 0");
        rd_chk(A_PEND, 32'h001, "R3 masked frame done");
        irq_chk(1'b0, "R9 pulse one cycle after event");
        step();
        irq_chk(1'b1, "R9 pulse on later event");
        step();
        irq_chk(1'b0, "R8 pulse ends");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_raw_only();
        t_enable_set();
        t_enable_clear();
        t_ack();
        t_eoi();
        t_collide();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule